// File: doc/BRIEF.md
# Pixel to Bus Cycle Packer

The packer sits between a pixel stream and the write side of a strobe sequencer that drives a parallel display bus. Pixels of 12, 16, 18 or 24 bits arrive on a valid/ready input. The packer cuts each pixel into bus words sized for a bus of 8, 9, 12 or 16 data lines and hands the words out on a second valid/ready port. It picks the cycle format from the ratio of pixel size to bus width: one, two or three transfers per pixel, or three transfers for every two pixels. In the last case a pixel pair is split across word boundaries.

A frame starts with a one-cycle `start` pulse. On that pulse the packer latches the pixel-size code, the bus-width code and the frame pixel count (width times height). It then takes exactly that many pixels and drains every word they produce. After that it drops `busy` and pulses `frame_done`, so the run enable clears without outside help. If the pixel size and bus width do not divide into a supported format, the start is refused and an error flag is raised.

Top module: `pixel_bus_packer`

## Requirements
- R1: `cfg_dtype` codes 0/1/2/3 select 12/16/18/24 bits per pixel and `cfg_width` codes 0/1/2/3 select 8/9/12/16 bus lines. After a start is accepted, `fmt_code` gives the derived format: 0 when bpp equals lines, 1 when bpp is twice lines, 2 when bpp is three times lines, 3 when twice bpp is three times lines.
- R2: A start with any other pixel-size and bus-width pair sets `cfg_err` in the next cycle and leaves `busy` and `in_ready` low. A later accepted start clears `cfg_err`.
- R3: In the two- and three-transfer formats, each pixel is sent most significant chunk first. A 16-bit pixel on 8 lines goes as bits 15:8, then 7:0. A 24-bit pixel on 8 lines goes as 23:16, then 15:8, then 7:0.
- R4: In the one-transfer format (16 bits on 16 lines, 12 bits on 12 lines), each pixel is exactly one word.
- R5: In the three-per-two format, a pixel pair is joined with the first pixel in the high part and cut into three words, high part first. For 24 bits on 16 lines: word 1 is p0[23:8], word 2 is {p0[7:0], p1[23:16]}, word 3 is p1[15:0].
- R6: Bus words are right-aligned, and the bits of `out_word` at and above the line count are zero. Pixel input bits at and above the pixel size are ignored.
- R7: While a frame runs, `busy` stays high until the programmed number of pixels has been taken and all their words have been handed out. `frame_done` is then high for one cycle, in the cycle in which `busy` goes low. `in_ready` stays low once the last pixel has been taken.
- R8: In the three-per-two format, if the frame count is odd, the last word carries the leftover high bits of the last pixel and its low bits are filled with zeros.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold their values. No word is dropped or repeated.
- R10: While `busy` is high, `start` and the configuration inputs are ignored. A start with a frame count of zero is ignored.
- R11: After reset, `busy`, `out_valid`, `in_ready`, `frame_done` and `cfg_err` are all low.
- R12: While idle, `in_ready` is low and no pixel is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dtype | input | 2 | Pixel size code |
| cfg_width | input | 2 | Bus width code |
| frame_pixels | input | CNT_W | Pixels per frame |
| start | input | 1 | Begin a frame (pulse) |
| in_valid | input | 1 | Input pixel valid |
| in_pixel | input | 24 | Input pixel, right-aligned |
| in_ready | output | 1 | Packer accepts a pixel |
| out_valid | output | 1 | Bus word valid |
| out_word | output | 16 | Bus word, right-aligned |
| out_ready | input | 1 | Sequencer accepts the word |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Last start was refused as unsupported |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| fmt_code | output | 2 | Latched cycle format |

## Verification
A wrong bit count in the accumulator shows up quickly. The first bus word after the fault appears shifted or with a wrong chunk, or an extra or missing word shows at the end of the frame, or `frame_done` never arrives. A pixel counter that is off by one either leaves the packer stuck waiting with `busy` high, or ends the frame early with `in_ready` still wanted. The word counts and the end-of-frame check reveal this at the end of that frame. A bad latched configuration shows in `fmt_code` in the cycle right after the start.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
    localparam int PIX_W = 24;
    localparam int BUS_W = 16;
    localparam int SZ_W  = 5;

    typedef enum logic [1:0] {
        FMT_1X1 = 2'd0,
        FMT_2X1 = 2'd1,
        FMT_3X1 = 2'd2,
        FMT_3X2 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic            ok;
        fmt_e            fmt;
        logic [SZ_W-1:0] bpp;
        logic [SZ_W-1:0] lines;
    } bus_cfg_t;

    function automatic logic [SZ_W-1:0] bpp_of(input logic [1:0] code);
        case (code)
            2'd0:    return SZ_W'(12);
            2'd1:    return SZ_W'(16);
            2'd2:    return SZ_W'(18);
            default: return SZ_W'(24);
        endcase
    endfunction

    function automatic logic [SZ_W-1:0] lines_of(input logic [1:0] code);
        case (code)
            2'd0:    return SZ_W'(8);
            2'd1:    return SZ_W'(9);
            2'd2:    return SZ_W'(12);
            default: return SZ_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/pbp_fmt_decode.sv
module pbp_fmt_decode
    import pbp_pkg::*;
(
    input  logic [1:0] dtype,
    input  logic [1:0] width,
    output bus_cfg_t   cfg
);
    localparam int EW = SZ_W + 2;

    logic [EW-1:0] b1, b2, l1, l2, l3;

    always_comb begin
        b1 = EW'(bpp_of(dtype));
        l1 = EW'(lines_of(width));
        b2 = b1 << 1;
        l2 = l1 << 1;
        l3 = l1 + l2;

        cfg.bpp   = bpp_of(dtype);
        cfg.lines = lines_of(width);
        cfg.ok    = 1'b1;
        cfg.fmt   = FMT_1X1;
        if (b1 == l1) begin
            cfg.fmt = FMT_1X1;
        end else if (b1 == l2) begin
            cfg.fmt = FMT_2X1;
        end else if (b1 == l3) begin
            cfg.fmt = FMT_3X1;
        end else if (b2 == l3) begin
            cfg.fmt = FMT_3X2;
        end else begin
            cfg.ok  = 1'b0;
        end
    end
endmodule

// File: rtl/pbp_frame_ctr.sv
module pbp_frame_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] target,
    input  logic             step,
    output logic             all_in
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             all_in;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        ctr_d   = ctr_q;
        cnt_inc = ctr_q.cnt + CNT_W'(1);
        if (load) begin
            ctr_d = '0;
        end else if (step && !ctr_q.all_in) begin
            ctr_d.cnt = cnt_inc;
            if (cnt_inc == target) begin
                ctr_d.all_in = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign all_in = ctr_q.all_in;

    // R7
    cnt_le_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.cnt <= target);

    // R7
    no_pixel_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !ctr_q.all_in);
endmodule

// File: rtl/pbp_packer.sv
module pbp_packer
    import pbp_pkg::*;
#(
    parameter int ACC_W = 2 * PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [SZ_W-1:0]  bpp,
    input  logic [SZ_W-1:0]  lines,
    input  logic             take,
    input  logic [PIX_W-1:0] pixel,
    input  logic             flush,
    input  logic             out_ready,
    output logic             can_take,
    output logic             word_valid,
    output logic [BUS_W-1:0] word,
    output logic             empty
);
    localparam int NB_W = $clog2(ACC_W + 1);
    localparam int EW   = SZ_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [NB_W-1:0]  nbits;
    } pk_t;

    pk_t pk_d, pk_q;

    logic             full_word;
    logic [PIX_W-1:0] pix_left;
    logic [ACC_W-1:0] ins;
    logic [BUS_W-1:0] top_bits;

    always_comb begin
        pk_d       = pk_q;
        full_word  = pk_q.nbits >= NB_W'(lines);
        can_take   = !full_word;
        word_valid = full_word || (flush && pk_q.nbits != '0);
        empty      = pk_q.nbits == '0;
        top_bits   = pk_q.acc[ACC_W-1 -: BUS_W];
        word       = BUS_W'(top_bits >> (BUS_W - int'(lines)));
        pix_left   = PIX_W'(pixel << (PIX_W - int'(bpp)));
        ins        = {pix_left, {(ACC_W - PIX_W){1'b0}}} >> pk_q.nbits;

        if (clear) begin
            pk_d = '0;
        end else if (take && can_take) begin
            pk_d.acc   = pk_q.acc | ins;
            pk_d.nbits = pk_q.nbits + NB_W'(bpp);
        end else if (word_valid && out_ready) begin
            pk_d.acc   = pk_q.acc << lines;
            pk_d.nbits = full_word ? (pk_q.nbits - NB_W'(lines)) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !out_ready && !clear) |=> (word_valid && $stable(word)));

    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.nbits != '0) |-> (EW'(pk_q.nbits) < EW'(lines) + EW'(bpp)));
endmodule

// File: rtl/pixel_bus_packer.sv
module pixel_bus_packer
    import pbp_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_dtype,
    input  logic [1:0]       cfg_width,
    input  logic [CNT_W-1:0] frame_pixels,
    input  logic             start,
    input  logic             in_valid,
    input  logic [23:0]      in_pixel,
    output logic             in_ready,
    output logic             out_valid,
    output logic [15:0]      out_word,
    input  logic             out_ready,
    output logic             busy,
    output logic             cfg_err,
    output logic             frame_done,
    output logic [1:0]       fmt_code
);
    typedef struct packed {
        logic             busy;
        logic             err;
        logic             done;
        bus_cfg_t         cfg;
        logic [CNT_W-1:0] target;
    } top_t;

    top_t     st_d, st_q;
    bus_cfg_t dec;
    logic     load, all_in, can_take, pk_valid, pk_empty, in_fire;

    pbp_fmt_decode u_dec (
        .dtype (cfg_dtype),
        .width (cfg_width),
        .cfg   (dec)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        if (start && !st_q.busy) begin
            st_d.err = !dec.ok;
            if (dec.ok && frame_pixels != '0) begin
                load        = 1'b1;
                st_d.busy   = 1'b1;
                st_d.cfg    = dec;
                st_d.target = frame_pixels;
            end
        end else if (st_q.busy && all_in && pk_empty) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = st_q.busy && !all_in && can_take;
    assign in_fire  = in_valid && in_ready;

    pbp_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .target (st_q.target),
        .step   (in_fire),
        .all_in (all_in)
    );

    pbp_packer u_pk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load),
        .bpp        (st_q.cfg.bpp),
        .lines      (st_q.cfg.lines),
        .take       (in_fire),
        .pixel      (in_pixel),
        .flush      (all_in),
        .out_ready  (out_ready && st_q.busy),
        .can_take   (can_take),
        .word_valid (pk_valid),
        .word       (out_word),
        .empty      (pk_empty)
    );

    assign out_valid  = st_q.busy && pk_valid;
    assign busy       = st_q.busy;
    assign cfg_err    = st_q.err;
    assign frame_done = st_q.done;
    assign fmt_code   = st_q.cfg.fmt;

    // R2
    err_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);

    // R2
    run_cfg_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> st_q.cfg.ok);

    // R6
    word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_word >> st_q.cfg.lines) == '0));

    // R7
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> frame_done);
endmodule

// File: tb/test_pixel_bus_packer.sv
`timescale 1ns/1ps
module test_pixel_bus_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_dtype = '0, cfg_width = '0;
    logic [19:0] frame_pixels = '0;
    logic        start = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
    logic [23:0] in_pixel = '0;
    logic        in_ready, out_valid, busy, cfg_err, frame_done;
    logic [15:0] out_word;
    logic [1:0]  fmt_code;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pixel_bus_packer i_pixel_bus_packer (
        .clk(clk), .rst_n(rst_n), .cfg_dtype(cfg_dtype), .cfg_width(cfg_width),
        .frame_pixels(frame_pixels), .start(start), .in_valid(in_valid),
        .in_pixel(in_pixel), .in_ready(in_ready), .out_valid(out_valid),
        .out_word(out_word), .out_ready(out_ready), .busy(busy),
        .cfg_err(cfg_err), .frame_done(frame_done), .fmt_code(fmt_code)
    );

    // {dtype, width, pixels, stall, expected format, expected words}
    localparam logic [22:0] VEC [12] = '{
        {2'd1, 2'd0, 8'd4, 1'b0, 2'd1, 8'd8},
        {2'd3, 2'd0, 8'd3, 1'b0, 2'd2, 8'd9},
        {2'd1, 2'd3, 8'd5, 1'b0, 2'd0, 8'd5},
        {2'd3, 2'd3, 8'd4, 1'b0, 2'd3, 8'd6},
        {2'd3, 2'd3, 8'd3, 1'b1, 2'd3, 8'd5},
        {2'd0, 2'd0, 8'd4, 1'b0, 2'd3, 8'd6},
        {2'd0, 2'd2, 8'd3, 1'b0, 2'd0, 8'd3},
        {2'd2, 2'd1, 8'd3, 1'b0, 2'd1, 8'd6},
        {2'd2, 2'd2, 8'd2, 1'b0, 2'd3, 8'd3},
        {2'd3, 2'd2, 8'd2, 1'b1, 2'd1, 8'd4},
        {2'd1, 2'd0, 8'd1, 1'b1, 2'd1, 8'd2},
        {2'd0, 2'd0, 8'd3, 1'b1, 2'd3, 8'd5}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int bpp_b(input int c);
        case (c) 0: return 12; 1: return 16; 2: return 18; default: return 24; endcase
    endfunction

    function automatic int lines_b(input int c);
        case (c) 0: return 8; 1: return 9; 2: return 12; default: return 16; endcase
    endfunction

    function automatic logic [23:0] pix(input int v, input int i);
        logic [31:0] t;
        t = 32'h9E3779B1 * 32'(v * 16 + i + 1);
        return t[27:4];
    endfunction

    function automatic logic exp_bit(input int v, input int bpp, input int n, input int j);
        logic [23:0] p;
        if (j >= n * bpp) return 1'b0;
        p = pix(v, j / bpp);
        return p[bpp - 1 - (j % bpp)];
    endfunction

    task automatic run_vec(input int v, input bit disturb);
        logic [22:0] e;
        int dt, wd, n, fmt, nw, bpp, lines, ng, idx, c, hold_err, extra, upper_bad;
        bit stall, done, pv;
        logic [15:0] pw, ew;
        logic [15:0] got [32];
        string tag;
        e = VEC[v];
        dt = int'(e[22:21]); wd = int'(e[20:19]); n = int'(e[18:11]);
        stall = e[10]; fmt = int'(e[9:8]); nw = int'(e[7:0]);
        bpp = bpp_b(dt); lines = lines_b(wd);
        ng = 0; idx = 0; c = 0; hold_err = 0; extra = 0; upper_bad = 0;
        done = 1'b0; pv = 1'b0; pw = '0;
        @(negedge clk);
        cfg_dtype = 2'(dt); cfg_width = 2'(wd); frame_pixels = 20'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        chk(int'(fmt_code) == fmt, "R1 format code", int'(fmt_code), fmt);
        chk(cfg_err == 1'b0, "R2 error cleared by good start", int'(cfg_err), 0);
        while (!done && c < 400) begin
            if (frame_done) begin
                done = 1'b1;
                chk(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
            end else begin
                if (pv && (!out_valid || out_word != pw)) hold_err++;
                out_ready = !(stall && (c % 3 == 2));
                pv = out_valid && !out_ready;
                pw = out_word;
                if (out_valid && out_ready) begin
                    if (ng < 32) got[ng] = out_word;
                    ng++;
                end
                if (idx < n) begin
                    in_valid = 1'b1;
                    in_pixel = pix(v, idx);
                    if (in_ready) idx++;
                end else begin
                    in_valid = 1'b0;
                    if (in_ready) extra++;
                end
                if (disturb && c == 2) begin
                    start = 1'b1; cfg_dtype = 2'd0; cfg_width = 2'd1; frame_pixels = 20'd1;
                end
                if (disturb && c == 3) start = 1'b0;
                c++;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        chk(done, "R7 frame done seen", int'(done), 1);
        chk(ng == nw, "R7 word count", ng, nw);
        chk(extra == 0, "R7 ready after last pixel", extra, 0);
        chk(hold_err == 0, "R9 hold under backpressure", hold_err, 0);
        if (disturb) chk(cfg_err == 1'b0, "R10 config ignored while busy", int'(cfg_err), 0);
        for (int k = 0; k < nw && k < ng && k < 32; k++) begin
            ew = '0;
            for (int b = 0; b < lines; b++) ew[lines - 1 - b] = exp_bit(v, bpp, n, k * lines + b);
            if ((got[k] >> lines) != 0) upper_bad++;
            if (fmt == 3 && k == nw - 1 && (n % 2) == 1) tag = "R8 padded word";
            else if (fmt == 3) tag = "R5 straddle word";
            else if (fmt == 0) tag = "R4 single word";
            else tag = "R3 chunk order";
            chk(got[k] == ew, tag, int'(got[k]), int'(ew));
        end
        chk(upper_bad == 0, "R6 upper bits zero", upper_bad, 0);
    endtask

    task automatic try_bad(input int dt, input int wd);
        @(negedge clk);
        cfg_dtype = 2'(dt); cfg_width = 2'(wd); frame_pixels = 20'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1, "R2 error raised", int'(cfg_err), 1);
        chk(busy == 1'b0 && in_ready == 1'b0, "R2 start blocked", int'({busy, in_ready}), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, out_valid, in_ready, frame_done, cfg_err} == 5'b0, "R11 reset state",
            int'({busy, out_valid, in_ready, frame_done, cfg_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, out_valid, in_ready, frame_done, cfg_err} == 5'b0, "R11 after reset",
            int'({busy, out_valid, in_ready, frame_done, cfg_err}), 0);

        in_valid = 1'b1;
        in_pixel = 24'hABCDEF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b0 && out_valid == 1'b0, "R12 idle takes nothing",
                int'({in_ready, out_valid}), 0);
        end
        in_valid = 1'b0;

        try_bad(1, 1);
        try_bad(2, 0);
        try_bad(0, 3);

        for (int v = 0; v < 12; v++) run_vec(v, 1'b0);

        @(negedge clk);
        cfg_dtype = 2'd1; cfg_width = 2'd3; frame_pixels = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0 && cfg_err == 1'b0, "R10 zero count ignored", int'({busy, cfg_err}), 0);

        run_vec(1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule